// File: doc/BRIEF.md
# Boot Image Selector with Application Watchdog

This block decides which configuration image a device loads next: the factory image at address zero or an application image whose start address software supplies. Software works through a small parameter port on the register clock. It stages a boot address and watchdog settings, and it reads current, previous and staged values through a two-bit view selector. It can also request a reconfiguration. A reconfiguration emits a one-cycle pulse that carries the target word address. The block then waits for a load-done input, and an image-ok flag stands in for the integrity check of the loaded image.

While the application image runs, a watchdog counts on its own timebase, independent of the register clock. The application must restart the watchdog with rising edges on a kick input, or disable it before launch. If the watchdog expires, the block forces a return to the factory image. Every reconfiguration records its cause. Before a new reconfiguration overwrites the current state, that state is copied into a previous-state snapshot, so software in the factory image can find out why it was started.

Top module: `remote_reconfig_ctrl`

## Requirements
- R1: After reset the block is in factory mode with reconfig_o low. The current and previous views read zero. The staged watchdog enable reads 1 and the staged timeout field reads all ones.
- R2: In factory mode, a write to index 4 (boot word address), index 2 (timeout field, low TO_W bits) or index 3 (enable, bit 0) changes the staged view, which is read with selector 2. A read strobe presents its data on rdata_o one clock later.
- R3: In application mode, writes are ignored and the staged view keeps its values.
- R4: In factory mode, cfg_go_i produces a pulse on reconfig_o one clock later. The pulse lasts exactly one cycle, and boot_addr_o then carries the staged boot word address.
- R5: On load_done_i with image_ok_i high and a nonzero target, the block enters application mode. The current view (selector 0) then shows the target at index 4 and the staged timeout at index 2.
- R6: If image_ok_i is low at load_done_i for a nonzero target, the block stays in factory mode, its current boot address reads 0, and the invalid-image cause bit is added.
- R7: Index 7 reads the cause: bit 0 is a software request, bit 1 is a watchdog expiry, bit 2 is an invalid image. Selector 0 gives the latest cause and selector 1 the one before it.
- R8: At each reconfiguration the previous view (selector 1) takes the values the current view held just before. Index 0 bit 0 reads the mode (1 = application).
- R9: In application mode with the watchdog enabled and no kicks, the counter is loaded with the timeout field times 2^LOW_W watchdog cycles. When it expires, a reconfiguration to address 0 follows, after that time plus a few synchronizer cycles.
- R10: Each rising edge of wd_kick_i reloads the counter. Kicks that are more frequent than the timeout prevent any fallback.
- R11: With the staged enable at 0, the application image runs without a watchdog and is never forced out.
- R12: In factory mode, and while a load is in progress, the watchdog never expires.
- R13: cfg_go_i is ignored in application mode and while a load is pending.
- R14: Selector 3 reads zero at every index, and indices 1, 5 and 6 read zero in every view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| wd_clk_i | input | 1 | Watchdog timebase clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Parameter write strobe |
| rd_en_i | input | 1 | Parameter read strobe |
| idx_i | input | 3 | Parameter index |
| src_i | input | 2 | View selector: 0 current, 1 previous, 2 staged, 3 none |
| wdata_i | input | ADDR_W | Write data |
| rdata_o | output | ADDR_W | Read data, valid one clock after the strobe |
| cfg_go_i | input | 1 | Software reconfiguration request |
| load_done_i | input | 1 | Image load finished |
| image_ok_i | input | 1 | Loaded image passed its check |
| wd_kick_i | input | 1 | Watchdog restart, counted on rising edges |
| reconfig_o | output | 1 | One-cycle reconfiguration pulse |
| boot_addr_o | output | ADDR_W | Word address of the image to load |
| app_mode_o | output | 1 | High while the application image runs |

## Verification
The assertions check four rules on every cycle: the reconfiguration pulse is one cycle wide, a pulse raised from application mode always targets address zero, application mode is entered only on a good load, and the watchdog toggle stays still while the watchdog is not armed. Reads through the empty view are also checked on every cycle. Expiry timing can only be shown by the bench's scenarios. These cover a sweep over every timeout field value with bounds computed from the field, the reload on kicks, cause and snapshot bookkeeping across successive reconfigurations, and the write and request lockout in application mode.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
    localparam int IDX_W   = 3;
    localparam int SRC_W   = 2;
    localparam int CAUSE_W = 3;

    localparam int CAUSE_SW  = 0;
    localparam int CAUSE_WDT = 1;
    localparam int CAUSE_BAD = 2;

    localparam logic [IDX_W-1:0] IDX_MODE  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_WDTO  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_WDEN  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_BOOT  = 3'd4;
    localparam logic [IDX_W-1:0] IDX_CAUSE = 3'd7;

    localparam logic [SRC_W-1:0] SRC_CUR   = 2'd0;
    localparam logic [SRC_W-1:0] SRC_PAST  = 2'd1;
    localparam logic [SRC_W-1:0] SRC_STAGE = 2'd2;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_LOAD = 1'b1
    } rrc_state_e;
endpackage

// File: rtl/rrc_sync.sv
module rrc_sync #(
    parameter int W = 1,
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [N-1:0][W-1:0] stage_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < N; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[N-1];
endmodule

// File: rtl/rrc_wdog.sv
module rrc_wdog #(
    parameter int TO_W   = 12,
    parameter int LOW_W  = 17,
    parameter int SYNC_N = 2
) (
    input  logic            wd_clk_i,
    input  logic            rst_ni,
    input  logic            run_i,
    input  logic            kick_i,
    input  logic [TO_W-1:0] to_i,
    output logic            armed_o,
    output logic            expire_tgl_o
);
    localparam int CNT_W = TO_W + LOW_W;

    typedef struct packed {
        logic             run_prev;
        logic             kick_prev;
        logic [CNT_W-1:0] cnt;
        logic             tgl;
    } wd_t;

    wd_t  wd_d, wd_q;
    logic run_s, kick_s;

    rrc_sync #(.W(1), .N(SYNC_N)) u_run_sync (
        .clk_i(wd_clk_i), .rst_ni(rst_ni), .d_i(run_i), .q_o(run_s)
    );

    rrc_sync #(.W(1), .N(SYNC_N)) u_kick_sync (
        .clk_i(wd_clk_i), .rst_ni(rst_ni), .d_i(kick_i), .q_o(kick_s)
    );

    always_comb begin
        logic start, kedge, fire;
        start = run_s & ~wd_q.run_prev;
        kedge = kick_s & ~wd_q.kick_prev;
        fire  = 1'b0;
        wd_d  = wd_q;
        wd_d.run_prev  = run_s;
        wd_d.kick_prev = kick_s;
        if (!run_s) begin
            wd_d.cnt = '0;
        end else if (start || kedge) begin
            wd_d.cnt = {to_i, {LOW_W{1'b0}}};
        end else if (wd_q.cnt != '0) begin
            wd_d.cnt = wd_q.cnt - CNT_W'(1);
            fire     = (wd_q.cnt == CNT_W'(1));
        end
        wd_d.tgl = wd_q.tgl ^ fire;
    end

    always_ff @(posedge wd_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign armed_o      = run_s;
    assign expire_tgl_o = wd_q.tgl;
endmodule

// File: rtl/rrc_rd_mux.sv
module rrc_rd_mux
    import rrc_pkg::*;
#(
    parameter int AW   = 24,
    parameter int TO_W = 12
) (
    input  logic [SRC_W-1:0]   src_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic               cur_mode_i,
    input  logic [AW-1:0]      cur_boot_i,
    input  logic [TO_W-1:0]    cur_to_i,
    input  logic               cur_en_i,
    input  logic [CAUSE_W-1:0] cur_cause_i,
    input  logic               past_mode_i,
    input  logic [AW-1:0]      past_boot_i,
    input  logic [TO_W-1:0]    past_to_i,
    input  logic               past_en_i,
    input  logic [CAUSE_W-1:0] past_cause_i,
    input  logic [AW-1:0]      stg_boot_i,
    input  logic [TO_W-1:0]    stg_to_i,
    input  logic               stg_en_i,
    output logic [AW-1:0]      data_o
);
    logic               v_mode;
    logic [AW-1:0]      v_boot;
    logic [TO_W-1:0]    v_to;
    logic               v_en;
    logic [CAUSE_W-1:0] v_cause;

    always_comb begin
        v_mode  = 1'b0;
        v_boot  = '0;
        v_to    = '0;
        v_en    = 1'b0;
        v_cause = '0;
        case (src_i)
            SRC_CUR: begin
                v_mode = cur_mode_i;  v_boot = cur_boot_i;  v_to = cur_to_i;
                v_en   = cur_en_i;    v_cause = cur_cause_i;
            end
            SRC_PAST: begin
                v_mode = past_mode_i; v_boot = past_boot_i; v_to = past_to_i;
                v_en   = past_en_i;   v_cause = past_cause_i;
            end
            SRC_STAGE: begin
                v_boot = stg_boot_i;  v_to = stg_to_i;      v_en = stg_en_i;
            end
            default: ;
        endcase
    end

    always_comb begin
        data_o = '0;
        case (idx_i)
            IDX_MODE:  data_o[0] = v_mode;
            IDX_WDTO:  data_o[TO_W-1:0] = v_to;
            IDX_WDEN:  data_o[0] = v_en;
            IDX_BOOT:  data_o = v_boot;
            IDX_CAUSE: data_o[CAUSE_W-1:0] = v_cause;
            default:   ;
        endcase
    end
endmodule

// File: rtl/remote_reconfig_ctrl.sv
module remote_reconfig_ctrl
    import rrc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int TO_W   = 12,
    parameter int LOW_W  = 17,
    parameter int SYNC_N = 2
) (
    input  logic              clk_i,
    input  logic              wd_clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] rdata_o,
    input  logic              cfg_go_i,
    input  logic              load_done_i,
    input  logic              image_ok_i,
    input  logic              wd_kick_i,
    output logic              reconfig_o,
    output logic [ADDR_W-1:0] boot_addr_o,
    output logic              app_mode_o
);
    typedef struct packed {
        logic               mode;
        logic [ADDR_W-1:0]  boot;
        logic [TO_W-1:0]    to;
        logic               en;
        logic [CAUSE_W-1:0] cause;
    } view_t;

    typedef struct packed {
        rrc_state_e        st;
        view_t             cur;
        view_t             past;
        logic [ADDR_W-1:0] stg_boot;
        logic [TO_W-1:0]   stg_to;
        logic              stg_en;
        logic [ADDR_W-1:0] tgt;
        logic              pulse;
        logic              wd_run;
        logic              tgl_prev;
        logic [ADDR_W-1:0] rdata;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              wd_armed, wd_tgl, tgl_s, expire;
    logic [ADDR_W-1:0] mux_data;

    rrc_wdog #(.TO_W(TO_W), .LOW_W(LOW_W), .SYNC_N(SYNC_N)) u_wdog (
        .wd_clk_i     (wd_clk_i),
        .rst_ni       (rst_ni),
        .run_i        (ctl_q.wd_run),
        .kick_i       (wd_kick_i),
        .to_i         (ctl_q.cur.to),
        .armed_o      (wd_armed),
        .expire_tgl_o (wd_tgl)
    );

    rrc_sync #(.W(1), .N(SYNC_N)) u_exp_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wd_tgl), .q_o(tgl_s)
    );

    assign expire = tgl_s ^ ctl_q.tgl_prev;

    rrc_rd_mux #(.AW(ADDR_W), .TO_W(TO_W)) u_rd_mux (
        .src_i        (src_i),
        .idx_i        (idx_i),
        .cur_mode_i   (ctl_q.cur.mode),
        .cur_boot_i   (ctl_q.cur.boot),
        .cur_to_i     (ctl_q.cur.to),
        .cur_en_i     (ctl_q.cur.en),
        .cur_cause_i  (ctl_q.cur.cause),
        .past_mode_i  (ctl_q.past.mode),
        .past_boot_i  (ctl_q.past.boot),
        .past_to_i    (ctl_q.past.to),
        .past_en_i    (ctl_q.past.en),
        .past_cause_i (ctl_q.past.cause),
        .stg_boot_i   (ctl_q.stg_boot),
        .stg_to_i     (ctl_q.stg_to),
        .stg_en_i     (ctl_q.stg_en),
        .data_o       (mux_data)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.pulse    = 1'b0;
        ctl_d.tgl_prev = tgl_s;
        if (rd_en_i) begin
            ctl_d.rdata = mux_data;
        end
        case (ctl_q.st)
            ST_RUN: begin
                if (!ctl_q.cur.mode && wr_en_i) begin
                    case (idx_i)
                        IDX_WDTO: ctl_d.stg_to   = wdata_i[TO_W-1:0];
                        IDX_WDEN: ctl_d.stg_en   = wdata_i[0];
                        IDX_BOOT: ctl_d.stg_boot = wdata_i;
                        default:  ;
                    endcase
                end
                if (!ctl_q.cur.mode && cfg_go_i) begin
                    ctl_d.past      = ctl_q.cur;
                    ctl_d.cur.cause = CAUSE_W'(1 << CAUSE_SW);
                    ctl_d.tgt       = ctl_q.stg_boot;
                    ctl_d.pulse     = 1'b1;
                    ctl_d.st        = ST_LOAD;
                end else if (ctl_q.cur.mode && expire) begin
                    ctl_d.past      = ctl_q.cur;
                    ctl_d.cur.cause = CAUSE_W'(1 << CAUSE_WDT);
                    ctl_d.tgt       = '0;
                    ctl_d.pulse     = 1'b1;
                    ctl_d.st        = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (load_done_i) begin
                    ctl_d.st = ST_RUN;
                    if ((ctl_q.tgt != '0) && image_ok_i) begin
                        ctl_d.cur.mode = 1'b1;
                        ctl_d.cur.boot = ctl_q.tgt;
                        ctl_d.cur.to   = ctl_q.stg_to;
                        ctl_d.cur.en   = ctl_q.stg_en;
                    end else begin
                        ctl_d.cur.mode = 1'b0;
                        ctl_d.cur.boot = '0;
                        ctl_d.cur.en   = 1'b0;
                        if (ctl_q.tgt != '0) begin
                            ctl_d.cur.cause[CAUSE_BAD] = 1'b1;
                        end
                    end
                end
            end
            default: ctl_d.st = ST_RUN;
        endcase
        ctl_d.wd_run = (ctl_d.st == ST_RUN) & ctl_d.cur.mode & ctl_d.cur.en;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q        <= '0;
            ctl_q.stg_to <= '1;
            ctl_q.stg_en <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdata_o     = ctl_q.rdata;
    assign reconfig_o  = ctl_q.pulse;
    assign boot_addr_o = ctl_q.tgt;
    assign app_mode_o  = ctl_q.cur.mode;
endmodule

// File: rtl/rrc_chk.sv
module rrc_chk #(
    parameter int AW = 24
) (
    input logic          clk_i,
    input logic          wd_clk_i,
    input logic          rst_ni,
    input logic          reconfig_o,
    input logic [AW-1:0] boot_addr_o,
    input logic          app_mode_o,
    input logic          load_done_i,
    input logic          image_ok_i,
    input logic          rd_en_i,
    input logic [1:0]    src_i,
    input logic [AW-1:0] rdata_o,
    input logic          wd_armed,
    input logic          wd_tgl
);
    // R4
    pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reconfig_o |=> !reconfig_o);

    // R9
    fallback_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reconfig_o && app_mode_o) |-> (boot_addr_o == '0));

    // R5
    app_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(app_mode_o) |-> ($past(load_done_i) && $past(image_ok_i)));

    // R12
    quiet_wdog_chk: assert property (@(posedge wd_clk_i) disable iff (!rst_ni)
        !wd_armed |=> $stable(wd_tgl));

    // R14
    null_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rd_en_i) && ($past(src_i) == 2'd3)) |-> (rdata_o == '0));
endmodule

bind remote_reconfig_ctrl rrc_chk #(.AW(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .wd_clk_i    (wd_clk_i),
    .rst_ni      (rst_ni),
    .reconfig_o  (reconfig_o),
    .boot_addr_o (boot_addr_o),
    .app_mode_o  (app_mode_o),
    .load_done_i (load_done_i),
    .image_ok_i  (image_ok_i),
    .rd_en_i     (rd_en_i),
    .src_i       (src_i),
    .rdata_o     (rdata_o),
    .wd_armed    (wd_armed),
    .wd_tgl      (wd_tgl)
);

// File: tb/remote_reconfig_ctrl_tb.sv
module remote_reconfig_ctrl_tb;
    localparam int AW = 24, TW = 4, LW = 3;

    logic clk = 1'b0, wd_clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, go = 0, ld = 0, ok = 0, kick = 0;
    logic [2:0] idx = '0;
    logic [1:0] src = '0;
    logic [AW-1:0] wdata = '0, rdata, baddr;
    logic pulse, app;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always #50 wd_clk = ~wd_clk;

    remote_reconfig_ctrl #(.ADDR_W(AW), .TO_W(TW), .LOW_W(LW), .SYNC_N(2)) u_dut (
        .clk_i(clk), .wd_clk_i(wd_clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .idx_i(idx), .src_i(src),
        .wdata_i(wdata), .rdata_o(rdata), .cfg_go_i(go), .load_done_i(ld),
        .image_ok_i(ok), .wd_kick_i(kick), .reconfig_o(pulse),
        .boot_addr_o(baddr), .app_mode_o(app)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0; rd_en = 0; go = 0; ld = 0; ok = 0; kick = 0;
        repeat (10) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input int i, input logic [AW-1:0] v);
        @(negedge clk); wr_en = 1; idx = 3'(i); wdata = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input int s, input int i, output logic [AW-1:0] v);
        @(negedge clk); rd_en = 1; src = 2'(s); idx = 3'(i);
        @(negedge clk); rd_en = 0; v = rdata;
    endtask

    task automatic rdchk(input string tag, input int s, input int i, input logic [AW-1:0] exp);
        logic [AW-1:0] v;
        rd(s, i, v);
        chk(tag, 32'(v), 32'(exp));
    endtask

    task automatic trigger(input logic [AW-1:0] exp_addr);
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
        chk("R4 pulse", 32'(pulse), 32'd1);
        chk("R4 addr", 32'(baddr), 32'(exp_addr));
        @(negedge clk);
        chk("R4 width", 32'(pulse), 32'd0);
    endtask

    task automatic finish_load(input logic good);
        @(negedge clk); ld = 1; ok = good;
        @(negedge clk); ld = 0; ok = 0;
    endtask

    task automatic wait_pulse(input int max, output int n, output bit seen);
        n = 0; seen = 0;
        while (n < max && !seen) begin
            @(negedge clk); n++;
            if (pulse) seen = 1;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog for all requirements act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int n; bit seen; int cnt;
        do_reset();
        // R1 reset state
        chk("R1 mode", 32'(app), 0);
        chk("R1 pulse", 32'(pulse), 0);
        rdchk("R1 cur boot", 0, 4, 0);
        rdchk("R1 past cause", 1, 7, 0);
        rdchk("R1 past mode", 1, 0, 0);
        rdchk("R1 stg en", 2, 3, 1);
        rdchk("R1 stg to", 2, 2, 24'hF);

        // R14 empty view and unused indices
        for (int i = 0; i < 8; i++) rdchk("R14 src3", 3, i, 0);
        for (int s = 0; s < 3; s++) begin
            rdchk("R14 idx1", s, 1, 0);
            rdchk("R14 idx5", s, 5, 0);
            rdchk("R14 idx6", s, 6, 0);
        end

        // R2 staged writes
        for (int k = 0; k < 8; k++) begin
            wr(4, 24'h020000 + 24'(k * 24'h1111));
            rdchk("R2 boot", 2, 4, 24'h020000 + 24'(k * 24'h1111));
        end
        for (int t = 0; t < 16; t++) begin
            wr(2, 24'(t) | 24'hAB0);
            rdchk("R2 to", 2, 2, 24'(t));
        end
        wr(3, 0); rdchk("R2 en0", 2, 3, 0);
        wr(3, 1); rdchk("R2 en1", 2, 3, 1);

        // R12 no watchdog in factory mode
        wait_pulse(400, n, seen);
        chk("R12 factory quiet", 32'(seen), 0);
        chk("R12 factory mode", 32'(app), 0);

        // R6 invalid image, R13 go during load
        wr(4, 24'h040000);
        trigger(24'h040000);
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
        wait_pulse(3, n, seen);
        chk("R13 go in load", 32'(seen), 0);
        finish_load(0);
        chk("R6 mode", 32'(app), 0);
        rdchk("R6 cause", 0, 7, 24'h5);
        rdchk("R6 boot", 0, 4, 0);
        rdchk("R7 past cause", 1, 7, 0);
        wait_pulse(400, n, seen);
        chk("R12 after bad load", 32'(seen), 0);

        // R9 sweep over every timeout field value
        for (int t = 1; t < 16; t++) begin
            int lw;
            logic [AW-1:0] b;
            lw = t * (1 << LW);
            b  = 24'h020000 + 24'(t);
            wr(2, 24'(t)); wr(3, 1); wr(4, b);
            trigger(b);
            finish_load(1);
            chk("R5 mode", 32'(app), 1);
            rdchk("R5 boot", 0, 4, b);
            rdchk("R5 to", 0, 2, 24'(t));
            rdchk("R7 sw cause", 0, 7, 24'h1);
            wait_pulse(5 * (lw + 6) + 20, n, seen);
            chk("R9 expired", 32'(seen), 1);
            chk("R9 not early", 32'(n >= 5 * (lw + 1)), 1);
            chk("R9 not late", 32'(n <= 5 * (lw + 4) + 8), 1);
            chk("R9 target", 32'(baddr), 0);
            finish_load(1);
            chk("R9 back", 32'(app), 0);
            rdchk("R7 wdt cause", 0, 7, 24'h2);
            rdchk("R7 prev cause", 1, 7, 24'h1);
            rdchk("R8 prev boot", 1, 4, b);
            rdchk("R8 prev mode", 1, 0, 1);
            rdchk("R8 prev to", 1, 2, 24'(t));
        end

        // R10 kicks hold the application image
        wr(2, 4); wr(4, 24'h020000);
        trigger(24'h020000);
        finish_load(1);
        cnt = 0;
        for (int p = 0; p < 20; p++) begin
            kick = 1;
            for (int c = 0; c < 30; c++) begin @(negedge clk); if (pulse) cnt++; end
            kick = 0;
            for (int c = 0; c < 30; c++) begin @(negedge clk); if (pulse) cnt++; end
        end
        chk("R10 no fallback", 32'(cnt), 0);
        chk("R10 still app", 32'(app), 1);
        kick = 1;
        wait_pulse(5 * 38 + 20, n, seen);
        kick = 0;
        chk("R10 expired", 32'(seen), 1);
        chk("R10 not early", 32'(n >= 5 * 33), 1);
        chk("R10 not late", 32'(n <= 5 * 36 + 8), 1);
        finish_load(1);
        rdchk("R10 cause", 0, 7, 24'h2);

        // R11 disabled watchdog, R3 and R13 lockouts
        wr(3, 0); wr(2, 1); wr(4, 24'h0ABCDE);
        trigger(24'h0ABCDE);
        finish_load(1);
        chk("R11 app", 32'(app), 1);
        rdchk("R11 cur en", 0, 3, 0);
        wr(4, 24'h012345); wr(3, 1); wr(2, 9);
        rdchk("R3 boot kept", 2, 4, 24'h0ABCDE);
        rdchk("R3 en kept", 2, 3, 0);
        rdchk("R3 to kept", 2, 2, 1);
        @(negedge clk); go = 1;
        @(negedge clk); go = 0;
        wait_pulse(3, n, seen);
        chk("R13 go in app", 32'(seen), 0);
        wait_pulse(400, n, seen);
        chk("R11 no fallback", 32'(seen), 0);
        chk("R11 still app", 32'(app), 1);

        do_reset();
        chk("R1 mode again", 32'(app), 0);
        rdchk("R1 cur cause", 0, 7, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule